// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps recently used leaf page-table translations close to the address path so that most memory accesses need no table walk. A requester presents a 20-bit virtual page number and, in the same cycle, learns whether a translation is held. On a hit it also receives the 20-bit physical frame number and five attribute bits. The array holds 32 entries as 4 ways by 8 sets, and each entry covers one 4 KB page, so a full array maps 128 KB.

After a walk completes, the walker installs the final table entry through a fill port. Directory-level entries are never offered to this block. A flush input clears every entry at once. The surrounding logic raises it whenever the directory base register is written, including on a task switch that reloads that register. The flush is the only means of removing stale translations after software changes the tables.

Both the lookup and fill inputs use a valid/ready handshake. Ready is high on every cycle except one in which flush is high. A lookup transfers when valid and ready are both high, and its response appears combinationally in that cycle. The response has no back-pressure of its own: a requester that cannot use it must keep lookup valid low. A fill that is offered while flush is high is not taken, and the walker must hold it and offer it again.

Top module: `pte_lookaside`

## Requirements
- R1: After reset every lookup misses.
- R2: A lookup uses VPN bits 2:0 as the set index and VPN bits 19:3 as the tag. It hits when a valid way in that set holds the tag. `rsp_valid_o` equals `lk_valid_i && lk_ready_o` in the same cycle, and on a hit the stored frame and attributes appear in that cycle.
- R3: On a miss, `rsp_frame_o` and `rsp_attr_o` are zero.
- R4: A fill accepted in cycle N is visible to a lookup in cycle N+1. The lookup returns the filled frame and attributes, with the attribute bits encoded as [0] user access, [1] writable, [2] dirty, [3] write-through, [4] cache-disable.
- R5: A fill whose VPN is already resident overwrites that way in place. No VPN is ever held twice, and the other ways keep their contents.
- R6: A fill for a VPN that is not resident goes to the lowest-numbered invalid way of its set, if the set has one.
- R7: When the set is full, the victim comes from a 3-bit tree pseudo-LRU state per set. Bit 0 selects the half: 0 means ways 0/1 and 1 means ways 2/3. Bit 1 selects within ways 0/1 and bit 2 selects within ways 2/3. Using way w sets bit 0 to the inverse of w[1] and sets the chosen half's bit to the inverse of w[0]. A fill uses its way. Otherwise, a lookup hit uses its way in its set.
- R8: A flush invalidates all 32 entries and clears the pseudo-LRU state. Every lookup in the following cycle misses.
- R9: While flush is high, `lk_ready_o` and `fill_ready_o` are low and any offered fill is dropped. Flush wins over a simultaneous fill.
- R10: Four different VPNs with the same set bits coexist. Thirty-two VPNs spread across all sets all hit together.
- R11: A lookup and a fill in the same cycle for the same VPN give the lookup the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_ready_o | output | 1 | Lookup can be accepted |
| lk_vpn_i | input | 20 | Lookup virtual page number |
| rsp_valid_o | output | 1 | Lookup response valid this cycle |
| rsp_hit_o | output | 1 | Translation found |
| rsp_frame_o | output | 20 | Physical frame number on hit |
| rsp_attr_o | output | 5 | Attribute bits on hit |
| fill_valid_i | input | 1 | Fill request valid |
| fill_ready_o | output | 1 | Fill can be accepted |
| fill_vpn_i | input | 20 | Virtual page number to install |
| fill_frame_i | input | 20 | Frame number to install |
| fill_attr_i | input | 5 | Attribute bits to install |

## Verification
The hardest situation to reach from the ports is a replacement in a full set whose pseudo-LRU state has been shaped by a mix of hits and fills. A pool of only six tags per set gives that, because random fills and lookups then fill sets quickly, hit often and evict repeatedly. A directed sequence fills one set, touches way 0 with a hit, and checks that way 2 is the way evicted. Collisions within one cycle are also generated deliberately: fill with lookup on the same VPN, and flush together with a fill.

// File: rtl/plb_pkg.sv
`timescale 1ns/1ps
package plb_pkg;
  localparam int VPN_W    = 20;
  localparam int FRAME_W  = 20;
  localparam int SET_BITS = 3;
  localparam int WAY_BITS = 2;
  localparam int WAYS     = 1 << WAY_BITS;
  localparam int SETS     = 1 << SET_BITS;
  localparam int TAG_W    = VPN_W - SET_BITS;
  localparam int ATTR_W   = 5;

  typedef struct packed {
    logic cd;     // bit 4
    logic wt;     // bit 3
    logic dirty;  // bit 2
    logic wr;     // bit 1
    logic user;   // bit 0
  } pattr_t;

  typedef struct packed {
    logic [TAG_W-1:0]   tag;
    logic [FRAME_W-1:0] frame;
    pattr_t             attr;
  } pent_t;

  function automatic logic [2:0] plru_touch(input logic [2:0] st, input logic [WAY_BITS-1:0] w);
    logic [2:0] n;
    n    = st;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/plb_way_array.sv
`timescale 1ns/1ps
module plb_way_array
  import plb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [SET_BITS-1:0]  rd_set,
  input  logic [TAG_W-1:0]     rd_tag,
  output logic [WAYS-1:0]      hit_vec,
  output pent_t [WAYS-1:0]     rd_ents,
  input  logic                 wr_en,
  input  logic [SET_BITS-1:0]  wr_set,
  input  logic [WAY_BITS-1:0]  wr_way,
  input  pent_t                wr_ent,
  output logic [WAYS-1:0]      wr_valid_vec,
  output logic [WAYS-1:0]      wr_match_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0] vbits;
    pent_t           mem [SETS];

    always_ff @(posedge clk) begin
      if (!rst_n || flush)                             vbits <= '0;
      else if (wr_en && wr_way == WAY_BITS'(w))        vbits[wr_set] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WAY_BITS'(w)) mem[wr_set] <= wr_ent;
    end

    assign hit_vec[w]      = vbits[rd_set] && (mem[rd_set].tag == rd_tag);
    assign rd_ents[w]      = mem[rd_set];
    assign wr_valid_vec[w] = vbits[wr_set];
    assign wr_match_vec[w] = vbits[wr_set] && (mem[wr_set].tag == wr_ent.tag);
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R5
endmodule

// File: rtl/plb_plru.sv
`timescale 1ns/1ps
module plb_plru
  import plb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                fill_en,
  input  logic [SET_BITS-1:0] fill_set,
  input  logic [WAY_BITS-1:0] fill_way,
  input  logic                hit_en,
  input  logic [SET_BITS-1:0] hit_set,
  input  logic [WAY_BITS-1:0] hit_way,
  output logic [WAY_BITS-1:0] tree_way
);
  logic [2:0] st [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n || flush)                               st[s] <= '0;
      else if (fill_en && fill_set == SET_BITS'(s))      st[s] <= plru_touch(st[s], fill_way);
      else if (hit_en && hit_set == SET_BITS'(s))        st[s] <= plru_touch(st[s], hit_way);
    end
  end

  logic [2:0] cur;
  assign cur      = st[fill_set];
  assign tree_way = cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};

  AST_TOUCH_MOVES_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> (tree_way[1] != $past(fill_way[1])) || (fill_set != $past(fill_set))); // R7
endmodule

// File: rtl/plb_victim.sv
`timescale 1ns/1ps
module plb_victim
  import plb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WAYS-1:0]     match_vec,
  input  logic [WAYS-1:0]     valid_vec,
  input  logic [WAY_BITS-1:0] tree_way,
  output logic [WAY_BITS-1:0] way
);
  always_comb begin
    logic found;
    way   = tree_way;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && match_vec[w]) begin
        way   = WAY_BITS'(w);
        found = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_vec[w]) begin
        way   = WAY_BITS'(w);
        found = 1'b1;
      end
    end
  end

  AST_REUSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_vec) |-> match_vec[way]); // R5
  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|match_vec) && !(&valid_vec)) |-> !valid_vec[way]); // R6
endmodule

// File: rtl/pte_lookaside.sv
`timescale 1ns/1ps
module pte_lookaside
  import plb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               lk_valid_i,
  output logic               lk_ready_o,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [FRAME_W-1:0] rsp_frame_o,
  output logic [ATTR_W-1:0]  rsp_attr_o,
  input  logic               fill_valid_i,
  output logic               fill_ready_o,
  input  logic [VPN_W-1:0]   fill_vpn_i,
  input  logic [FRAME_W-1:0] fill_frame_i,
  input  logic [ATTR_W-1:0]  fill_attr_i
);
  logic [SET_BITS-1:0] lk_set, fl_set;
  logic [TAG_W-1:0]    lk_tag;
  logic [WAYS-1:0]     hit_vec, wr_valid_vec, wr_match_vec;
  pent_t [WAYS-1:0]    rd_ents;
  pent_t               wr_ent;
  logic [WAY_BITS-1:0] hit_way, tree_way, vic_way;
  logic                lk_fire, fill_fire, any_hit;

  assign lk_ready_o   = !flush_i;
  assign fill_ready_o = !flush_i;
  assign lk_fire      = lk_valid_i && lk_ready_o;
  assign fill_fire    = fill_valid_i && fill_ready_o;

  assign lk_set = lk_vpn_i[SET_BITS-1:0];
  assign lk_tag = lk_vpn_i[VPN_W-1:SET_BITS];
  assign fl_set = fill_vpn_i[SET_BITS-1:0];
  assign wr_ent = '{tag: fill_vpn_i[VPN_W-1:SET_BITS], frame: fill_frame_i, attr: pattr_t'(fill_attr_i)};

  plb_way_array u_arr (
    .clk(clk), .rst_n(rst_n), .flush(flush_i),
    .rd_set(lk_set), .rd_tag(lk_tag), .hit_vec(hit_vec), .rd_ents(rd_ents),
    .wr_en(fill_fire), .wr_set(fl_set), .wr_way(vic_way), .wr_ent(wr_ent),
    .wr_valid_vec(wr_valid_vec), .wr_match_vec(wr_match_vec)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_BITS'(w);
  end
  assign any_hit = |hit_vec;

  plb_plru u_plru (
    .clk(clk), .rst_n(rst_n), .flush(flush_i),
    .fill_en(fill_fire), .fill_set(fl_set), .fill_way(vic_way),
    .hit_en(lk_fire && any_hit), .hit_set(lk_set), .hit_way(hit_way),
    .tree_way(tree_way)
  );

  plb_victim u_vic (
    .clk(clk), .rst_n(rst_n),
    .match_vec(wr_match_vec), .valid_vec(wr_valid_vec),
    .tree_way(tree_way), .way(vic_way)
  );

  assign rsp_valid_o = lk_fire;
  assign rsp_hit_o   = lk_fire && any_hit;
  assign rsp_frame_o = rsp_hit_o ? rd_ents[hit_way].frame : '0;
  assign rsp_attr_o  = rsp_hit_o ? rd_ents[hit_way].attr  : '0;

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !rsp_hit_o); // R1
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> (!fill_ready_o && !rsp_valid_o)); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !rsp_hit_o); // R8
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fill_fire) && rsp_valid_o && lk_vpn_i == $past(fill_vpn_i))
      |-> (rsp_hit_o && rsp_frame_o == $past(fill_frame_i) && rsp_attr_o == $past(fill_attr_i))); // R4
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_frame_o == '0 && rsp_attr_o == '0)); // R3
endmodule

// File: tb/sim_pte_lookaside.sv
`timescale 1ns/1ps
module sim_pte_lookaside;
  logic clk = 1'b0, rst_n = 1'b0, flush_i = 1'b0;
  logic lk_valid_i = 1'b0, lk_ready_o, rsp_valid_o, rsp_hit_o;
  logic [19:0] lk_vpn_i = '0, rsp_frame_o, fill_vpn_i = '0, fill_frame_i = '0;
  logic [4:0]  rsp_attr_o, fill_attr_i = '0;
  logic fill_valid_i = 1'b0, fill_ready_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pte_lookaside u0 (.*);

  bit         mv [8][4];
  logic [16:0] mt [8][4];
  logic [19:0] mf [8][4];
  logic [4:0]  ma [8][4];
  logic [2:0]  mp [8];

  function automatic logic [2:0] touch(logic [2:0] st, int w);
    logic [2:0] n = st;
    n[0] = (w < 2);
    if (w >= 2) n[2] = (w == 2); else n[1] = (w == 0);
    return n;
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic mclear();
    for (int s = 0; s < 8; s++) begin
      mp[s] = 0;
      for (int w = 0; w < 4; w++) mv[s][w] = 0;
    end
  endtask

  task automatic mlook(logic [19:0] v, output bit h, output int hw);
    h = 0; hw = 0;
    for (int w = 0; w < 4; w++)
      if (mv[v[2:0]][w] && mt[v[2:0]][w] == v[19:3]) begin h = 1; hw = w; end
  endtask

  task automatic cyc(bit lv, logic [19:0] lvpn, bit fv, logic [19:0] fvpn,
                     logic [19:0] ff, logic [4:0] fa, bit fl, string rq);
    bit h; int hw; int s, vw; bit found;
    @(negedge clk);
    lk_valid_i = lv; lk_vpn_i = lvpn; fill_valid_i = fv; fill_vpn_i = fvpn;
    fill_frame_i = ff; fill_attr_i = fa; flush_i = fl;
    #1;
    chk(lk_ready_o === !fl && fill_ready_o === !fl, "R9 ready", {lk_ready_o, fill_ready_o}, {!fl, !fl});
    mlook(lvpn, h, hw);
    if (lv) begin
      chk(rsp_valid_o === !fl, "R2 rsp_valid", rsp_valid_o, !fl);
      if (!fl) begin
        chk(rsp_hit_o === h, {rq, " hit"}, rsp_hit_o, h);
        if (h) chk(rsp_frame_o === mf[lvpn[2:0]][hw] && rsp_attr_o === ma[lvpn[2:0]][hw],
                   {rq, " R2 data"}, {rsp_attr_o, rsp_frame_o}, {ma[lvpn[2:0]][hw], mf[lvpn[2:0]][hw]});
        else   chk(rsp_frame_o === '0 && rsp_attr_o === '0, "R3 miss zero",
                   {rsp_attr_o, rsp_frame_o}, 0);
      end
    end
    @(posedge clk);
    if (fl) mclear();
    else begin
      if (fv) begin
        s = fvpn[2:0]; found = 0; vw = 0;
        for (int w = 0; w < 4; w++) if (!found && mv[s][w] && mt[s][w] == fvpn[19:3]) begin vw = w; found = 1; end
        for (int w = 0; w < 4; w++) if (!found && !mv[s][w]) begin vw = w; found = 1; end
        if (!found) vw = mp[s][0] ? (2 + mp[s][2]) : int'(mp[s][1]);
        mv[s][vw] = 1; mt[s][vw] = fvpn[19:3]; mf[s][vw] = ff; ma[s][vw] = fa;
        mp[s] = touch(mp[s], vw);
      end
      if (lv && h && !(fv && fvpn[2:0] == lvpn[2:0]))
        mp[lvpn[2:0]] = touch(mp[lvpn[2:0]], hw);
    end
  endtask

  task automatic look(logic [19:0] v, string rq);
    cyc(1, v, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic fill(logic [19:0] v, logic [19:0] f, logic [4:0] a);
    cyc(0, 0, 1, v, f, a, 0, "R4 fill");
  endtask
  task automatic expect_hit(logic [19:0] v, bit e, string rq);
    @(negedge clk);
    lk_valid_i = 1; lk_vpn_i = v; fill_valid_i = 0; flush_i = 0;
    #1;
    chk(rsp_hit_o === e, rq, rsp_hit_o, e);
    lk_valid_i = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    mclear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: empty after reset
    for (int i = 0; i < 8; i++) expect_hit(20'(i * 37), 0, "R1 reset miss");
    // R4 / R2: install and read back
    fill(20'h12345, 20'hABCDE, 5'b10101);
    look(20'h12345, "R4 visible");
    expect_hit(20'h12345, 1, "R4 hit");
    // R11: same-cycle fill and lookup of same vpn
    cyc(1, 20'h00F0B, 1, 20'h00F0B, 20'h11111, 5'h1F, 0, "R11 pre-fill");
    look(20'h00F0B, "R11 post-fill");
    // R5: refill in place
    fill(20'h12345, 20'h22222, 5'b00011);
    look(20'h12345, "R5 overwrite");
    // R9: flush beats fill
    cyc(0, 0, 1, 20'h77777, 20'h1, 5'h1, 1, "R9 flush fill");
    expect_hit(20'h77777, 0, "R9 dropped fill");
    expect_hit(20'h12345, 0, "R8 flushed");
    // R6/R7: set 5, four tags, then hit way0, fifth fill evicts way2
    for (int t = 0; t < 4; t++) fill({17'(t + 1), 3'd5}, 20'(t), 5'(t));
    for (int t = 0; t < 4; t++) expect_hit({17'(t + 1), 3'd5}, 1, "R10 four ways");
    look({17'd1, 3'd5}, "R7 touch way0");
    fill({17'd9, 3'd5}, 20'h9, 5'h9);
    expect_hit({17'd3, 3'd5}, 0, "R7 way2 evicted");
    expect_hit({17'd1, 3'd5}, 1, "R7 way0 kept");
    expect_hit({17'd2, 3'd5}, 1, "R7 way1 kept");
    expect_hit({17'd4, 3'd5}, 1, "R7 way3 kept");
    expect_hit({17'd9, 3'd5}, 1, "R6 new entry");
    // R8 flush then R10: 32 entries all resident
    cyc(0, 0, 0, 0, 0, 0, 1, "R8 flush");
    for (int i = 0; i < 32; i++) fill({17'(i / 8 + 100), 3'(i % 8)}, 20'(i * 3), 5'(i));
    for (int i = 0; i < 32; i++) look({17'(i / 8 + 100), 3'(i % 8)}, "R10 all sets");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [19:0] lv_, fv_;
      int r = $urandom_range(0, 99);
      lv_ = {17'($urandom_range(0, 5)), 3'($urandom_range(0, 7))};
      fv_ = (r < 10) ? lv_ : {17'($urandom_range(0, 5)), 3'($urandom_range(0, 7))};
      cyc($urandom_range(0, 3) != 0, lv_, r < 45, fv_, 20'($urandom), 5'($urandom),
          $urandom_range(0, 199) == 0, "R7 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule